// File: doc/BRIEF.md
# SCL Timing Generator for an I2C Master

This block places every edge of an I2C master's clock line and every data change on a kernel-clock grid. One packed 32-bit timing word sets a prescaler, the SCL low and high counts, a hold delay and a setup delay. Each delay runs on its own down-counter, so the point where SDA may change and the point where SCL may rise are set apart from each other, and not by one divided clock. The outputs are open-drain pull enables for SCL and SDA, a strobe that asks the bit engine to present its next bit, and a strobe that marks the moment to sample SDA.

A bit engine drives the block with a valid/ready command port. The commands are START, data bit, STOP and repeated START. After a command completes, SCL is left held low and the block waits for the next command. The high phase is timed only after the synchronised SCL input is seen high. A slave can therefore stretch the clock by holding the line low.

Top module: `scl_timing_gen`

## Requirements
- R1: The timing word packs five fields. The low count sits in bits 7:0, the high count in bits 15:8, the hold field in bits 19:16, the setup field in bits 23:20 and the prescaler in bits 31:28. One time unit U is (prescaler+1) kernel clocks. The durations are TL=(low+1)·U, TH=(high+1)·U, THO=hold·U+1 and TS=(setup+1)·U.
- R2: Commands are coded 00 data bit, 01 START, 10 STOP and 11 repeated START. A START accepted while the bus is idle pulls SDA low on the accepting clock edge. SCL is pulled low TH clocks later.
- R3: SDA changes only while SCL is held low. A data-bit command is accepted, with the shift strobe high, in the cycle that ends THO clocks after SCL fell. On that edge, sda_pull takes the inverse of tx_bit.
- R4: SCL is released max(TL, THO+TS) clocks after it was pulled low, given that the command is waiting when the hold delay expires.
- R5: The high count starts on the third clock edge after the SCL input goes high. SCL is pulled low again TH clocks later, so a slave holding SCL low delays the whole high phase.
- R6: During a data bit the sample strobe is high for exactly one cycle per high phase. That cycle comes TH−1−floor(TH/2) clocks after the high count starts.
- R7: STOP pulls SDA low once the hold delay expires. It releases SCL as in R4, and it releases SDA TH clocks after the high count starts. The block then returns to idle with cmd_ready high.
- R8: Repeated START releases SDA once the hold delay expires and releases SCL as in R4. It pulls SDA low TH clocks after the high count starts, then pulls SCL low TH clocks after that.
- R9: The timing word is captured only while enable is low. Changes made while enable is high do not alter any duration.
- R10: While enable is low, or after reset, both pull outputs, both strobes and cmd_ready are low. Dropping enable mid-transfer releases both lines on the next edge.
- R11: In the idle state, a command other than START is accepted and has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; timing word captured while low |
| timing_word | input | 32 | Packed timing configuration |
| cmd_valid | input | 1 | Command present |
| cmd | input | 2 | Command code |
| tx_bit | input | 1 | Data bit to place on SDA for a data-bit command |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| scl_in | input | 1 | SCL line level as seen on the pad |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| shift_stb | output | 1 | Next SDA bit is taken this cycle |
| sample_stb | output | 1 | Sample SDA this cycle |

## Verification
The bench sweeps prescaler, setup, hold, low and high fields over a small grid. For every setting it runs START, data bits, repeated START and STOP, and it stretches the clock by several amounts. It targets the case where the hold plus setup time exceeds the low count. A design that timed the release from only one counter would raise SCL before the data had settled. It also targets a stretched high phase, where a design that counted from the release would cut the high time short. A one-clock high phase is covered too, where an off-by-one midpoint would give no sample strobe or two of them. Writes to the timing word while enabled, and an abort by dropping enable, are checked at the pins.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int PRESC_W   = 4;
  localparam int DLY_W     = 4;
  localparam int PER_W     = 8;
  localparam int PRESC_LSB = 28;
  localparam int SETUP_LSB = 20;
  localparam int HOLD_LSB  = 16;
  localparam int HIGH_LSB  = 8;
  localparam int LOW_LSB   = 0;
  localparam int LEN_W     = PER_W + PRESC_W + 1;

  typedef enum logic [1:0] {
    CMD_BIT     = 2'b00,
    CMD_START   = 2'b01,
    CMD_STOP    = 2'b10,
    CMD_RESTART = 2'b11
  } tg_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START_HOLD, ST_LOW, ST_SETUP, ST_HIGH_WAIT, ST_HIGH
  } tg_state_e;

  typedef enum logic [1:0] {OP_BIT, OP_STOP, OP_RESTART} tg_op_e;

  // all lengths stored minus one, ready to load into a down-counter
  typedef struct packed {
    logic [LEN_W-1:0] low_m1;
    logic [LEN_W-1:0] high_m1;
    logic [LEN_W-1:0] hold_m1;
    logic [LEN_W-1:0] setup_m1;
    logic [LEN_W-1:0] high_mid;
  } tg_len_t;
endpackage

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scl_tg_cfg.sv
module scl_tg_cfg
  import scl_tg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing_word,
  output tg_len_t     len
);
  logic [LEN_W-1:0] unit, lo_full, hi_full, su_full;
  tg_len_t          len_n, len_q;
  logic             unused_rsvd;

  assign unused_rsvd = ^timing_word[PRESC_LSB-1:SETUP_LSB+DLY_W];

  always_comb begin
    unit    = LEN_W'(timing_word[PRESC_LSB +: PRESC_W]) + LEN_W'(1);
    lo_full = (LEN_W'(timing_word[LOW_LSB +: PER_W]) + LEN_W'(1)) * unit;
    hi_full = (LEN_W'(timing_word[HIGH_LSB +: PER_W]) + LEN_W'(1)) * unit;
    su_full = (LEN_W'(timing_word[SETUP_LSB +: DLY_W]) + LEN_W'(1)) * unit;
    len_n.low_m1   = lo_full - LEN_W'(1);
    len_n.high_m1  = hi_full - LEN_W'(1);
    len_n.hold_m1  = LEN_W'(timing_word[HOLD_LSB +: DLY_W]) * unit;
    len_n.setup_m1 = su_full - LEN_W'(1);
    len_n.high_mid = hi_full >> 1;
  end

  // capture only while the peripheral is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (!enable) len_q <= len_n;
  end

  assign len = len_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(len_q)); // R9
endmodule

// File: rtl/scl_tg_down_cnt.sv
module scl_tg_down_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = load_val;
    else if (cnt_q != '0)  cnt_n = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

  AST_CNT_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R4
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing_word,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd,
  input  logic        tx_bit,
  output logic        cmd_ready,
  input  logic        scl_in,
  output logic        scl_pull,
  output logic        sda_pull,
  output logic        shift_stb,
  output logic        sample_stb
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  tg_len_t          len;
  tg_cmd_e          cmd_e;
  tg_state_e        state_q, state_n;
  tg_op_e           op_q, op_n;
  logic             scl_q, scl_n, sda_q, sda_n;
  logic             scl_seen;
  logic             ph_ld, dt_ld, ph_zero, dt_zero;
  logic [LEN_W-1:0] ph_val, dt_val, ph_cnt, dt_cnt_unused;
  logic             ready_c, shift_c;
  logic             samp_seen_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cmd_e = tg_cmd_e'(cmd);

  scl_tg_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .enable(enable),
    .timing_word(timing_word), .len(len)
  );

  scl_tg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_int_n), .d(scl_in), .q(scl_seen)
  );

  scl_tg_down_cnt #(.W(LEN_W)) u_phase_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(ph_ld), .load_val(ph_val),
    .count(ph_cnt), .zero(ph_zero)
  );

  scl_tg_down_cnt #(.W(LEN_W)) u_data_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(dt_ld), .load_val(dt_val),
    .count(dt_cnt_unused), .zero(dt_zero)
  );

  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    scl_n   = scl_q;
    sda_n   = sda_q;
    ph_ld   = 1'b0;
    ph_val  = len.high_m1;
    dt_ld   = 1'b0;
    dt_val  = len.hold_m1;
    ready_c = 1'b0;
    shift_c = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ready_c = 1'b1;
        if (cmd_valid && cmd_e == CMD_START) begin
          sda_n   = 1'b1;
          ph_ld   = 1'b1;
          ph_val  = len.high_m1;
          state_n = ST_START_HOLD;
        end
      end
      ST_START_HOLD: begin
        if (ph_zero) begin
          scl_n   = 1'b1;
          ph_ld   = 1'b1;
          ph_val  = len.low_m1;
          dt_ld   = 1'b1;
          dt_val  = len.hold_m1;
          state_n = ST_LOW;
        end
      end
      ST_LOW: begin
        ready_c = dt_zero;
        if (cmd_valid && dt_zero) begin
          dt_ld   = 1'b1;
          dt_val  = len.setup_m1;
          state_n = ST_SETUP;
          case (cmd_e)
            CMD_BIT: begin
              shift_c = 1'b1;
              sda_n   = ~tx_bit;
              op_n    = OP_BIT;
            end
            CMD_STOP: begin
              sda_n = 1'b1;
              op_n  = OP_STOP;
            end
            default: begin
              sda_n = 1'b0;
              op_n  = OP_RESTART;
            end
          endcase
        end
      end
      ST_SETUP: begin
        if (ph_zero && dt_zero) begin
          scl_n   = 1'b0;
          state_n = ST_HIGH_WAIT;
        end
      end
      ST_HIGH_WAIT: begin
        if (scl_seen) begin
          ph_ld   = 1'b1;
          ph_val  = len.high_m1;
          state_n = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (ph_zero) begin
          case (op_q)
            OP_BIT: begin
              scl_n   = 1'b1;
              ph_ld   = 1'b1;
              ph_val  = len.low_m1;
              dt_ld   = 1'b1;
              dt_val  = len.hold_m1;
              state_n = ST_LOW;
            end
            OP_STOP: begin
              sda_n   = 1'b0;
              state_n = ST_IDLE;
            end
            default: begin
              sda_n   = 1'b1;
              ph_ld   = 1'b1;
              ph_val  = len.high_m1;
              state_n = ST_START_HOLD;
            end
          endcase
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (!enable) begin
      state_n = ST_IDLE;
      scl_n   = 1'b0;
      sda_n   = 1'b0;
      ph_ld   = 1'b0;
      dt_ld   = 1'b0;
      ready_c = 1'b0;
      shift_c = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_BIT;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      scl_q   <= scl_n;
      sda_q   <= sda_n;
    end
  end

  assign scl_pull   = scl_q;
  assign sda_pull   = sda_q;
  assign cmd_ready  = ready_c;
  assign shift_stb  = shift_c;
  assign sample_stb = enable && (state_q == ST_HIGH) && (op_q == OP_BIT) &&
                      (ph_cnt == len.high_mid);

  // tracks whether this high phase has already produced its sample strobe
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      samp_seen_q <= 1'b0;
    else if (scl_q)      samp_seen_q <= 1'b0;
    else if (sample_stb) samp_seen_q <= 1'b1;
  end

  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_stb |-> !samp_seen_q); // R6
  AST_SHIFT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_stb |-> (scl_pull && !sample_stb)); // R3
  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_HIGH && op_q == OP_BIT) |-> $stable(sda_pull)); // R3
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable |=> (!scl_pull && !sda_pull && state_q == ST_IDLE)); // R10
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n, enable, cmd_valid, tx_bit, stretch;
  logic [31:0] timing_word;
  logic [1:0]  cmd;
  logic        cmd_ready, scl_in, scl_pull, sda_pull, shift_stb, sample_stb;
  int          cyc = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  int          U, TL, TH, THO, TS;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = !(scl_pull || stretch);

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timing_word(timing_word),
    .cmd_valid(cmd_valid), .cmd(cmd), .tx_bit(tx_bit), .cmd_ready(cmd_ready),
    .scl_in(scl_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1: field placement and duration arithmetic
  task automatic set_cfg(input int p, input int su, input int hd, input int sh, input int sl);
    @(negedge clk);
    enable = 1'b0;
    timing_word = {p[3:0], 4'h0, su[3:0], hd[3:0], sh[7:0], sl[7:0]};
    U = p + 1; TL = (sl + 1) * U; TH = (sh + 1) * U; THO = hd * U + 1; TS = (su + 1) * U;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_scl(input logic v, output int st);
    while (scl_pull !== v) @(negedge clk);
    st = cyc;
  endtask

  task automatic do_start(output int f);
    int a;
    cmd = 2'b01; cmd_valid = 1'b1; #1;
    chk("R2 ready in idle", cmd_ready, 1);
    a = cyc + 1;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R2 sda low at accept", sda_pull, 1);
    wait_scl(1'b1, f);
    chk("R2 scl fall after TH (R1)", f - a, TH);
  endtask

  task automatic do_bit(input int f, input logic b, input int k, output int fn);
    int s, r, hs, ns, sst;
    cmd = 2'b00; tx_bit = b; cmd_valid = 1'b1; stretch = 1'b1; #1;
    while (!cmd_ready) @(negedge clk);
    s = cyc;
    chk("R3 shift time", s, f + THO - 1);
    chk("R3 shift strobe", shift_stb, 1);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R3 sda value", sda_pull, !b);
    chk("R3 scl still low at sda change", scl_pull, 1);
    wait_scl(1'b0, r);
    chk("R4 low length (R1)", r - f, imax(TL, THO + TS));
    repeat (k) @(negedge clk);
    stretch = 1'b0;
    ns = 0; sst = -1;
    while (scl_pull !== 1'b1) begin
      if (sample_stb) begin ns++; sst = cyc; chk("R6 sda held at sample", sda_pull, !b); end
      @(negedge clk);
    end
    fn = cyc;
    hs = r + k + 3;
    chk("R5 high end with stretch", fn, hs + TH);
    chk("R6 one sample", ns, 1);
    chk("R6 sample position", sst, hs + TH - 1 - TH / 2);
  endtask

  task automatic do_stop(input int f);
    int s, r, e;
    cmd = 2'b10; cmd_valid = 1'b1; stretch = 1'b1; #1;
    while (!cmd_ready) @(negedge clk);
    s = cyc;
    chk("R7 stop accept time", s, f + THO - 1);
    chk("R7 no shift on stop", shift_stb, 0);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R7 sda low before stop", sda_pull, 1);
    wait_scl(1'b0, r);
    chk("R7 release", r - f, imax(TL, THO + TS));
    stretch = 1'b0;
    while (sda_pull !== 1'b0) @(negedge clk);
    e = cyc;
    chk("R7 sda release", e, r + 3 + TH);
    #1;
    chk("R7 back to idle", {scl_pull, cmd_ready}, 1);
  endtask

  task automatic do_restart(input int f, output int fn);
    int r, g;
    cmd = 2'b11; cmd_valid = 1'b1; stretch = 1'b1; #1;
    while (!cmd_ready) @(negedge clk);
    chk("R8 restart accept time", cyc, f + THO - 1);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R8 sda released", sda_pull, 0);
    wait_scl(1'b0, r);
    chk("R8 scl release", r - f, imax(TL, THO + TS));
    stretch = 1'b0;
    while (sda_pull !== 1'b1) @(negedge clk);
    g = cyc;
    chk("R8 sda low again", g, r + 3 + TH);
    wait_scl(1'b1, fn);
    chk("R8 scl low after hold", fn, g + TH);
  endtask

  initial begin
    int f;
    rst_n = 1'b0; enable = 1'b0; cmd_valid = 1'b0; cmd = 2'b00; tx_bit = 1'b0;
    stretch = 1'b0; timing_word = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset scl", scl_pull, 0);
    chk("R10 reset sda", sda_pull, 0);
    chk("R10 reset strobes", {shift_stb, sample_stb, cmd_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int p = 0; p < 3; p++)
      for (int su = 0; su < 3; su++)
        for (int hd = 0; hd < 3; hd++)
          for (int li = 0; li < 3; li++)
            for (int hi = 0; hi < 2; hi++) begin
              set_cfg(p, su, hd, hi * 4, (li == 0) ? 0 : ((li == 1) ? 3 : 9));
              do_start(f);
              do_bit(f, 1'b1, 0, f);
              do_bit(f, 1'b0, (p + su + hd) % 4, f);
              if (hi == 1) begin
                do_restart(f, f);
                do_bit(f, 1'b1, 1, f);
              end
              do_stop(f);
            end

    // R9: timing word written while enabled has no effect
    set_cfg(0, 0, 0, 3, 5);
    do_start(f);
    timing_word = 32'hF0FF_FFFF;
    do_bit(f, 1'b0, 0, f);
    do_stop(f);

    // R11: non-start command while idle leaves the bus alone
    cmd = 2'b00; cmd_valid = 1'b1; #1;
    chk("R11 accepted in idle", cmd_ready, 1);
    repeat (4) @(negedge clk);
    chk("R11 bus untouched", {scl_pull, sda_pull, shift_stb, sample_stb}, 0);
    cmd_valid = 1'b0;

    // R10: abort by dropping enable in mid transfer
    set_cfg(1, 2, 1, 2, 6);
    do_start(f);
    cmd = 2'b00; tx_bit = 1'b0; cmd_valid = 1'b1; stretch = 1'b1;
    repeat (THO + 1) @(negedge clk);
    cmd_valid = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk("R10 abort releases", {scl_pull, sda_pull, cmd_ready}, 0);
    stretch = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    do_start(f);
    do_stop(f);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule